// File: doc/BRIEF.md
# Framing-Bit Error Window Monitor

This block watches the framing bits of a received signal and raises a level flag when framing quality has degraded badly. A framer upstream gives a one-cycle strobe for every framing bit it checks. With each strobe comes an error indication and the framer's current in-frame status. The monitor keeps a sliding record of the most recent framing-bit results. It sets its flag as soon as too many of those results are errors.

The set and clear conditions are deliberately asymmetric. The flag rises on error density alone. It falls only when the error density is back below the threshold and the framer also reports that it is in frame. The window moves only on framing-bit strobes, so clock cycles between strobes have no effect. The window length and the error threshold are parameters, with defaults of 16 bits and 3 errors.

Top module: `fbit_err_monitor`

## Requirements
- R1: After reset the flag is 0 and the window holds no errors. Two errors strobed right after reset therefore leave the flag at 0.
- R2: On a strobe, if 3 or more of the last 16 strobed bits are errors (the current one included), the flag is 1 after that clock edge.
- R3: On a strobe where fewer than 3 of the last 16 strobed bits are errors and in_frame is 1, the flag is 0 after that clock edge.
- R4: On a strobe where fewer than 3 of the last 16 strobed bits are errors and in_frame is 0, the flag keeps its previous value.
- R5: In a cycle with fbit_stb at 0, fbit_err and in_frame have no effect. Neither the flag nor the window changes.
- R6: The window counts strobes, not clock cycles. An error leaves the window at the 16th strobe after the strobe that carried it.
- R7: The flag changes value only at a clock edge where fbit_stb was 1, or through reset.
- R8: The error count kept alongside the window always equals the number of error bits stored in the window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fbit_stb | input | 1 | One-cycle strobe, one per framing bit checked |
| fbit_err | input | 1 | 1 when the strobed framing bit was in error |
| in_frame | input | 1 | Framer in-frame status, sampled on strobes |
| sev_err_flag | output | 1 | 1 while the severe framing-error condition holds |

## Verification
The checker tests the following on every cycle: set on threshold, clear when in frame, hold when out of frame, no change without a strobe, and agreement between the running count and the stored window. Some behaviour only the bench's scenarios can show. One case is errors aging out exactly sixteen strobes later. Another is a flag raised while the framer is out of frame. A third is a full window of errors draining down to the clear point. The bench also shows that reset empties the window.

// File: rtl/fbit_mon_pkg.sv
package fbit_mon_pkg;

  // One step of the running error count: add the entering bit, drop the leaving bit.
  function automatic int unsigned win_count_step(int unsigned cnt, logic add_bit, logic drop_bit);
    int unsigned r;
    r = cnt;
    if (add_bit)  r = r + 1;
    if (drop_bit) r = r - 1;
    return r;
  endfunction

  // Threshold test on the count.
  function automatic logic meets_threshold(int unsigned cnt, int unsigned thresh);
    return (cnt >= thresh);
  endfunction

  // Next flag value from the current flag, strobe, threshold result and framing status.
  function automatic logic flag_next(logic cur, logic strobe, logic over, logic framed);
    logic r;
    r = cur;
    if (strobe) begin
      if (over)        r = 1'b1;
      else if (framed) r = 1'b0;
    end
    return r;
  endfunction

endpackage

// File: rtl/fbit_window.sv
module fbit_window #(
  parameter int WIN_LEN = 16,
  parameter int CNT_W   = $clog2(WIN_LEN + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               shift_en,
  input  logic               err_in,
  output logic [WIN_LEN-1:0] win_q,
  output logic [CNT_W-1:0]   cnt_q,
  output logic [CNT_W-1:0]   cnt_next
);
  import fbit_mon_pkg::*;

  logic               drop_bit;
  logic [WIN_LEN-1:0] win_next;

  assign drop_bit = win_q[WIN_LEN-1];

  generate
    if (WIN_LEN == 1) begin : g_single
      assign win_next = err_in;
    end else begin : g_multi
      assign win_next = {win_q[WIN_LEN-2:0], err_in};
    end
  endgenerate

  always_comb begin
    cnt_next = cnt_q;
    if (shift_en)
      cnt_next = CNT_W'(win_count_step(32'(cnt_q), err_in, drop_bit));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= '0;
      cnt_q <= '0;
    end else if (shift_en) begin
      win_q <= win_next;
      cnt_q <= cnt_next;
    end
  end

endmodule

// File: rtl/fbit_flag_ctrl.sv
module fbit_flag_ctrl #(
  parameter int SET_THRESH = 3,
  parameter int CNT_W      = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe,
  input  logic             framed,
  input  logic [CNT_W-1:0] cnt_next,
  output logic             set_evt,
  output logic             clr_evt,
  output logic             flag_q
);
  import fbit_mon_pkg::*;

  logic over;

  assign over    = meets_threshold(32'(cnt_next), SET_THRESH);
  assign set_evt = strobe && over;
  assign clr_evt = strobe && !over && framed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_next(flag_q, strobe, over, framed);
  end

endmodule

// File: rtl/fbit_err_monitor.sv
module fbit_err_monitor #(
  parameter int WIN_LEN    = 16,
  parameter int SET_THRESH = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fbit_stb,
  input  logic fbit_err,
  input  logic in_frame,
  output logic sev_err_flag
);
  localparam int CNT_W = $clog2(WIN_LEN + 1);

  logic [WIN_LEN-1:0] win_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [CNT_W-1:0]   cnt_next;
  logic               set_evt;
  logic               clr_evt;

  fbit_window #(.WIN_LEN(WIN_LEN), .CNT_W(CNT_W)) win_i (
    .clk(clk), .rst_n(rst_n), .shift_en(fbit_stb), .err_in(fbit_err),
    .win_q(win_q), .cnt_q(cnt_q), .cnt_next(cnt_next)
  );

  fbit_flag_ctrl #(.SET_THRESH(SET_THRESH), .CNT_W(CNT_W)) flag_i (
    .clk(clk), .rst_n(rst_n), .strobe(fbit_stb), .framed(in_frame),
    .cnt_next(cnt_next), .set_evt(set_evt), .clr_evt(clr_evt), .flag_q(sev_err_flag)
  );

endmodule

// File: rtl/fbit_err_monitor_chk.sv
module fbit_err_monitor_chk #(
  parameter int WIN_LEN = 16,
  parameter int CNT_W   = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               fbit_stb,
  input logic               in_frame,
  input logic               set_evt,
  input logic               clr_evt,
  input logic               flag,
  input logic [WIN_LEN-1:0] win,
  input logic [CNT_W-1:0]   cnt
);
  // R2
  a_r2_set_on_density: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> flag);
  // R3
  a_r3_clear_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    clr_evt |=> !flag);
  // R4
  a_r4_hold_out_of_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (fbit_stb && !set_evt && !in_frame) |=> $stable(flag));
  // R5
  a_r5_no_strobe_window: assert property (@(posedge clk) disable iff (!rst_n)
    !fbit_stb |=> ($stable(win) && $stable(cnt)));
  // R7
  a_r7_flag_only_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !fbit_stb |=> $stable(flag));
  // R8
  a_r8_count_matches_window: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt) == $countones(win));
endmodule

bind fbit_err_monitor fbit_err_monitor_chk #(.WIN_LEN(WIN_LEN), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .fbit_stb(fbit_stb), .in_frame(in_frame),
  .set_evt(set_evt), .clr_evt(clr_evt), .flag(sev_err_flag), .win(win_q), .cnt(cnt_q)
);

// File: tb/fbit_err_monitor_tb_top.sv
module fbit_err_monitor_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fbit_stb = 1'b0;
  logic fbit_err = 1'b0;
  logic in_frame = 1'b0;
  logic sev_err_flag;
  int   n_checks = 0;
  int   n_errors = 0;

  always #5 clk = ~clk;

  fbit_err_monitor dut_i (
    .clk(clk), .rst_n(rst_n), .fbit_stb(fbit_stb), .fbit_err(fbit_err),
    .in_frame(in_frame), .sev_err_flag(sev_err_flag)
  );

  // Entry bits: [3] strobe, [2] error, [1] in_frame, [0] expected flag after the edge
  localparam int NVEC = 25;
  localparam logic [3:0] VEC [NVEC] = '{
    4'b1110, // s1 err, count 1 (R2)
    4'b1010, // s2 ok, count 1
    4'b0110, // no strobe, error ignored (R5)
    4'b1110, // s3 err, count 2 (R2)
    4'b1101, // s4 err out of frame, count 3 sets (R2)
    4'b1011, // s5 ok, count 3
    4'b1011, 4'b1011, 4'b1011, 4'b1011, 4'b1011, 4'b1011,
    4'b1011, 4'b1011, 4'b1011, 4'b1011, 4'b1011, // s6..s16, count 3 holds (R6)
    4'b1001, // s17 s1 ages out, count 2, out of frame holds (R4, R6)
    4'b1001, // s18 count 2, out of frame holds (R4)
    4'b0111, // no strobe, in frame, flag holds (R5, R7)
    4'b1010, // s19 count 1, in frame clears (R3)
    4'b1000, // s20 count 0, out of frame stays clear
    4'b1100, // s21 err, count 1
    4'b1100, // s22 err, count 2
    4'b1101  // s23 err, count 3, sets while out of frame (R2)
  };

  task automatic check(input string tag, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: flag=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic e, input logic f);
    @(negedge clk);
    fbit_stb = v; fbit_err = e; in_frame = f;
    @(posedge clk);
    #1;
    fbit_stb = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset value", sev_err_flag, 1'b0);
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][3], VEC[i][2], VEC[i][1]);
      check($sformatf("R2/R3/R4/R5/R6 vector %0d", i), sev_err_flag, VEC[i][0]);
    end

    // R1: reset while set empties the window
    @(negedge clk) rst_n = 1'b0;
    #1 check("R1 reset clears flag", sev_err_flag, 1'b0);
    @(negedge clk) rst_n = 1'b1;
    step(1, 1, 1); step(1, 1, 1);
    check("R1 window empty after reset", sev_err_flag, 1'b0);
    step(1, 1, 1);
    check("R2 third error sets", sev_err_flag, 1'b1);

    // R5/R7: idle cycles with error and framing toggling leave the flag
    for (int k = 0; k < 5; k++) step(0, k[0], 1);
    check("R7 idle cycles keep flag", sev_err_flag, 1'b1);

    // R6: full window of errors, then drain with good bits in frame
    for (int k = 0; k < 16; k++) step(1, 1, 1);
    check("R2 full error window", sev_err_flag, 1'b1);
    for (int k = 0; k < 13; k++) step(1, 0, 1);
    check("R6 three errors remain after 13 good", sev_err_flag, 1'b1);
    step(1, 0, 1);
    check("R3 clears when count drops to 2", sev_err_flag, 1'b0);
    step(1, 0, 0);
    check("R4 out of frame alone keeps clear", sev_err_flag, 1'b0);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule